// File: doc/BRIEF.md
# ATA Status and Device Control Register Block

This block sits between the host register bus of an ATA-style storage device and the device's internal controller. It builds the 8-bit status byte from the flags the controller supplies. The host can read that byte at two offsets. The main Status offset acknowledges a pending interrupt. The Alternate Status offset returns the same byte and has no side effect. A host write to the Alternate Status offset goes to a Device Control register instead. That register holds an active-low interrupt enable and a level-held soft-reset request.

Interrupts come from a one-cycle event pulse sent by the controller. The pulse sets a pending latch. The host interrupt request is that latch qualified by the enable. The same qualified value is also exported for the configuration-and-status logic that sits elsewhere. While soft reset is requested, the block reports the device as busy and keeps the latch cleared. Soft reset only acts through the `soft_rst` output. Configuration state is cleared by the hardware reset `rst_n` alone.

The pending latch is a three-state machine:
- `IRQ_CLEAR`: no interrupt pending.
- `IRQ_PEND`: an interrupt is pending.
- `IRQ_HELD`: soft reset is active.

Its transitions are:
- `IRQ_CLEAR`→`IRQ_PEND` on an event.
- `IRQ_PEND`→`IRQ_CLEAR` on a Status read that has no event in the same cycle.
- Any state→`IRQ_HELD` when the soft-reset bit will be 1 after the current edge.
- `IRQ_HELD`→`IRQ_CLEAR` when soft reset is released, or `IRQ_HELD`→`IRQ_PEND` if an event arrives in that release cycle.

The Device Control machine has two states, `DC_RUN` and `DC_SRST`:
- A control write with bit 2 = 1 enters `DC_SRST`.
- A control write with bit 2 = 0 returns to `DC_RUN`.
- With no control write, the state holds.

Top module: `ata_status_ctrl`

## Requirements
- R1: `host_rdata` shows the status byte when `host_rd` is 1 and `host_addr` is 4'h7 or 4'hE. It reads 8'h00 at any other offset, and whenever `host_rd` is 0. The read path is combinational.
- R2: The status byte is built as follows when not busy. Bit 6 is `ctl_rdy`. Bit 5 is `ctl_dwf`. Bit 4 is `ctl_dsc`. Bit 3 is `ctl_drq`. Bit 2 is `ctl_corr`. Bit 0 is `ctl_err`. Bit 7 is 0.
- R3: Bit 1 of the status byte is always 0.
- R4: Bit 7 (busy) is 1 when `ctl_busy` is 1 or soft reset is active. Bits 6..0 then read 0, so the byte is 8'h80.
- R5: A `ctl_irq_evt` pulse sets the pending latch at the next edge. `irq_req` and `cfg_irq_flag` both equal pending AND NOT nIEn.
- R6: A Status read (offset 4'h7) clears the pending latch at the next edge. If an event arrives in the same cycle, the latch stays set.
- R7: An Alternate Status read (offset 4'hE) returns the same byte as a Status read and leaves the pending latch unchanged.
- R8: A host write to offset 4'hE loads Device Control bit 1 as nIEn (1 = interrupts masked). Masking does not discard a pending interrupt. nIEn is 1 after hardware reset.
- R9: Device Control bit 2 drives `soft_rst` from the edge of the write. The bit stays 1 until the host writes it to 0. Hardware reset sets it to 0.
- R10: While soft reset is active, the pending latch is held clear and events are ignored. After soft reset is released, the latch stays clear.
- R11: Device Control bits 7..3 and bit 0 have no effect on `soft_rst`, `irq_req` or the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_addr | input | 4 | Host register offset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| ctl_busy | input | 1 | Controller busy flag |
| ctl_rdy | input | 1 | Controller ready to accept a command |
| ctl_dwf | input | 1 | Write fault flag |
| ctl_dsc | input | 1 | Seek complete flag |
| ctl_drq | input | 1 | Data request flag |
| ctl_corr | input | 1 | Corrected data error flag |
| ctl_err | input | 1 | Previous command ended in error |
| ctl_irq_evt | input | 1 | One-cycle interrupt event pulse |
| irq_req | output | 1 | Host interrupt request |
| cfg_irq_flag | output | 1 | Enable-gated interrupt state for configuration logic |
| soft_rst | output | 1 | Soft-reset level to the controller |

## Verification
The hardest cases to reach from the ports are those where two things meet in one cycle. One is a Status read landing in the same cycle as a new event. The other is an event arriving while soft reset is held. The bench first builds up a pending interrupt. It then holds the read strobe and the event pulse together for one cycle, and checks that the request survives. It also pulses an event under soft reset and then releases soft reset. Finally it unmasks interrupts and checks that no stale request appears.

// File: rtl/ata_regs_pkg.sv
package ata_regs_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned BIT_BUSY = 7;
    localparam int unsigned BIT_RDY  = 6;
    localparam int unsigned BIT_DWF  = 5;
    localparam int unsigned BIT_DSC  = 4;
    localparam int unsigned BIT_DRQ  = 3;
    localparam int unsigned BIT_CORR = 2;
    localparam int unsigned BIT_ERR  = 0;
    localparam int unsigned DC_SRST_BIT = 2;
    localparam int unsigned DC_NIEN_BIT = 1;

    typedef struct packed {
        logic busy;
        logic rdy;
        logic dwf;
        logic dsc;
        logic drq;
        logic corr;
        logic err;
    } ctl_flags_t;

    typedef enum logic [1:0] {
        IRQ_CLEAR = 2'd0,
        IRQ_PEND  = 2'd1,
        IRQ_HELD  = 2'd2
    } irq_state_t;

    typedef enum logic {
        DC_RUN  = 1'b0,
        DC_SRST = 1'b1
    } dc_state_t;

endpackage

// File: rtl/ata_devctl_reg.sv
module ata_devctl_reg
    import ata_regs_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              srst_q,
    output logic              srst_next,
    output logic              nien_q
);

    dc_state_t state_q, state_d;
    logic      nien_d;

    always_comb begin
        state_d = state_q;
        nien_d  = nien_q;
        if (wr_en) begin
            state_d = wdata[DC_SRST_BIT] ? DC_SRST : DC_RUN;
            nien_d  = wdata[DC_NIEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DC_RUN;
            nien_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            nien_q  <= nien_d;
        end
    end

    always_comb begin
        unique case (state_q)
            DC_RUN:  srst_q = 1'b0;
            DC_SRST: srst_q = 1'b1;
            default: srst_q = 1'b0;
        endcase
        srst_next = (state_d == DC_SRST);
    end

endmodule

// File: rtl/ata_irq_latch.sv
module ata_irq_latch
    import ata_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack_rd,
    input  logic srst_next,
    input  logic nien,
    output logic pending,
    output logic irq_gated
);

    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_CLEAR: if (evt) state_d = IRQ_PEND;
            IRQ_PEND:  if (ack_rd && !evt) state_d = IRQ_CLEAR;
            IRQ_HELD:  state_d = evt ? IRQ_PEND : IRQ_CLEAR;
            default:   state_d = IRQ_CLEAR;
        endcase
        if (srst_next) state_d = IRQ_HELD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_PEND:  pending = 1'b1;
            IRQ_CLEAR,
            IRQ_HELD:  pending = 1'b0;
            default:   pending = 1'b0;
        endcase
        irq_gated = pending && !nien;
    end

endmodule

// File: rtl/ata_status_view.sv
module ata_status_view
    import ata_regs_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  ctl_flags_t        flags,
    input  logic              srst,
    output logic [DATA_W-1:0] status
);

    always_comb begin
        status = '0;
        if (flags.busy || srst) begin
            status[BIT_BUSY] = 1'b1;
        end else begin
            status[BIT_RDY]  = flags.rdy;
            status[BIT_DWF]  = flags.dwf;
            status[BIT_DSC]  = flags.dsc;
            status[BIT_DRQ]  = flags.drq;
            status[BIT_CORR] = flags.corr;
            status[BIT_ERR]  = flags.err;
        end
    end

endmodule

// File: rtl/ata_status_ctrl.sv
module ata_status_ctrl
    import ata_regs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = BYTE_W,
    parameter logic [3:0]  STATUS_OFS = 4'h7,
    parameter logic [3:0]  ALT_OFS    = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ctl_busy,
    input  logic              ctl_rdy,
    input  logic              ctl_dwf,
    input  logic              ctl_dsc,
    input  logic              ctl_drq,
    input  logic              ctl_corr,
    input  logic              ctl_err,
    input  logic              ctl_irq_evt,
    output logic              irq_req,
    output logic              cfg_irq_flag,
    output logic              soft_rst
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] ALT_A  = ADDR_W'(ALT_OFS);

    logic              sel_stat, sel_alt;
    logic              dc_wr, stat_ack;
    logic              dc_srst, dc_srst_next, dc_nien;
    logic              irq_pending, irq_gated;
    logic [DATA_W-1:0] status_byte;
    ctl_flags_t        flags;

    assign sel_stat = (host_addr == STAT_A);
    assign sel_alt  = (host_addr == ALT_A);
    assign dc_wr    = host_wr && sel_alt;
    assign stat_ack = host_rd && sel_stat;

    assign flags = '{busy: ctl_busy, rdy: ctl_rdy, dwf: ctl_dwf, dsc: ctl_dsc,
                     drq: ctl_drq, corr: ctl_corr, err: ctl_err};

    ata_devctl_reg #(.DATA_W(DATA_W)) u_devctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dc_wr),
        .wdata     (host_wdata),
        .srst_q    (dc_srst),
        .srst_next (dc_srst_next),
        .nien_q    (dc_nien)
    );

    ata_irq_latch u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (ctl_irq_evt),
        .ack_rd    (stat_ack),
        .srst_next (dc_srst_next),
        .nien      (dc_nien),
        .pending   (irq_pending),
        .irq_gated (irq_gated)
    );

    ata_status_view #(.DATA_W(DATA_W)) u_view (
        .flags  (flags),
        .srst   (dc_srst),
        .status (status_byte)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd && (sel_stat || sel_alt)) host_rdata = status_byte;
    end

    assign irq_req      = irq_gated;
    assign cfg_irq_flag = irq_gated;
    assign soft_rst     = dc_srst;

endmodule

// File: rtl/ata_status_ctrl_chk.sv
module ata_status_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] host_addr,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       ctl_irq_evt,
    input logic       irq_req,
    input logic       soft_rst,
    input logic       nien
);

    logic rd_stat, rd_alt, wr_dc;
    assign rd_stat = host_rd && host_addr == 4'h7;
    assign rd_alt  = host_rd && host_addr == 4'hE;
    assign wr_dc   = host_wr && host_addr == 4'hE;

    assert_idx_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[1] == 1'b0);

    assert_busy_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && host_rdata[7]) |-> (host_rdata[6:0] == 7'd0));

    assert_srst_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && (rd_stat || rd_alt)) |-> (host_rdata == 8'h80));

    assert_idle_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> (host_rdata == 8'h00));

    assert_evt_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq_evt && !host_wr && !soft_rst && !nien) |=> irq_req);

    assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !nien);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !ctl_irq_evt) |=> !irq_req);

    assert_alt_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && rd_alt && !host_wr) |=> irq_req);

    assert_srst_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dc |=> (soft_rst == $past(host_wdata[2])));

    assert_srst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !wr_dc) |=> soft_rst);

    assert_srst_noirq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !irq_req);

endmodule

bind ata_status_ctrl ata_status_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .ctl_irq_evt (ctl_irq_evt),
    .irq_req     (irq_req),
    .soft_rst    (soft_rst),
    .nien        (dc_nien)
);

// File: tb/ata_status_ctrl_tb_top.sv
module ata_status_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ctl_busy = 0, ctl_rdy = 0, ctl_dwf = 0, ctl_dsc = 0;
    logic       ctl_drq = 0, ctl_corr = 0, ctl_err = 0, ctl_irq_evt = 0;
    logic       irq_req, cfg_irq_flag, soft_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    ata_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctl_busy(ctl_busy), .ctl_rdy(ctl_rdy), .ctl_dwf(ctl_dwf),
        .ctl_dsc(ctl_dsc), .ctl_drq(ctl_drq), .ctl_corr(ctl_corr),
        .ctl_err(ctl_err), .ctl_irq_evt(ctl_irq_evt), .irq_req(irq_req),
        .cfg_irq_flag(cfg_irq_flag), .soft_rst(soft_rst)
    );

    // {busy,rdy,dwf,dsc,drq,corr,err} , expected status byte
    localparam logic [14:0] VEC [10] = '{
        {7'b0000000, 8'h00}, {7'b0100000, 8'h40}, {7'b0010000, 8'h20},
        {7'b0001000, 8'h10}, {7'b0000100, 8'h08}, {7'b0000010, 8'h04},
        {7'b0000001, 8'h01}, {7'b0111111, 8'h7D}, {7'b1111111, 8'h80},
        {7'b1000000, 8'h80}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic set_flags(input logic [6:0] f);
        {ctl_busy, ctl_rdy, ctl_dwf, ctl_dsc, ctl_drq, ctl_corr, ctl_err} = f;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #3 d = host_rdata;
        step();
        host_rd = 1'b0;
    endtask

    task automatic wr_dc(input logic [7:0] v);
        host_addr = 4'hE; host_wr = 1'b1; host_wdata = v;
        step();
        host_wr = 1'b0;
    endtask

    task automatic pulse_evt();
        ctl_irq_evt = 1'b1;
        step();
        ctl_irq_evt = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d, d2;
        repeat (3) step();
        chk("R9 reset soft_rst", {7'd0, soft_rst}, 8'h00);
        chk("R5 reset irq_req", {7'd0, irq_req}, 8'h00);
        rst_n = 1'b1;
        step();

        // R2 R3 R4 vector table
        for (int i = 0; i < 10; i++) begin
            set_flags(VEC[i][14:8]);
            rd(4'h7, d);
            chk("R2/R4 status vector", d, VEC[i][7:0]);
        end
        set_flags(7'b0111111);
        rd(4'hE, d);
        chk("R7 alt same byte", d, 8'h7D);
        chk("R3 idx bit", {7'd0, d[1]}, 8'h00);
        rd(4'h3, d);
        chk("R1 other offset", d, 8'h00);
        #3 chk("R1 no strobe", host_rdata, 8'h00);
        set_flags(7'b0);

        // R8: masked after reset, pending kept
        pulse_evt();
        chk("R8 masked at reset", {7'd0, irq_req}, 8'h00);
        wr_dc(8'h00);
        chk("R8 unmask shows pending", {7'd0, irq_req}, 8'h01);
        chk("R5 cfg flag", {7'd0, cfg_irq_flag}, 8'h01);

        // R7 alt read keeps pending
        rd(4'hE, d);
        chk("R7 alt keeps pending", {7'd0, irq_req}, 8'h01);

        // R6 status read clears
        rd(4'h7, d);
        chk("R6 status read clears", {7'd0, irq_req}, 8'h00);

        // R5 event sets
        pulse_evt();
        chk("R5 event sets", {7'd0, irq_req}, 8'h01);

        // R6 same-cycle read and event
        host_addr = 4'h7; host_rd = 1'b1; ctl_irq_evt = 1'b1;
        step();
        host_rd = 1'b0; ctl_irq_evt = 1'b0;
        chk("R6 event beats read", {7'd0, irq_req}, 8'h01);

        // R8 mask and unmask keeps pending
        wr_dc(8'h02);
        chk("R8 masked", {7'd0, irq_req}, 8'h00);
        chk("R8 cfg masked", {7'd0, cfg_irq_flag}, 8'h00);
        wr_dc(8'h00);
        chk("R8 unmasked again", {7'd0, irq_req}, 8'h01);

        // R9 R10 soft reset
        wr_dc(8'h04);
        chk("R9 soft_rst set", {7'd0, soft_rst}, 8'h01);
        chk("R10 pending cleared", {7'd0, irq_req}, 8'h00);
        set_flags(7'b0100001);
        rd(4'h7, d);
        chk("R4 busy in soft reset", d, 8'h80);
        pulse_evt();
        repeat (4) step();
        chk("R9 soft_rst held", {7'd0, soft_rst}, 8'h01);
        chk("R10 event ignored", {7'd0, irq_req}, 8'h00);

        // R11 ignored bits: 0xF9 -> srst 0, nIEn 0
        wr_dc(8'hF9);
        chk("R11 srst cleared", {7'd0, soft_rst}, 8'h00);
        chk("R10 no stale irq", {7'd0, irq_req}, 8'h00);
        rd(4'h7, d);
        chk("R11 status unaffected", d, 8'h41);
        pulse_evt();
        chk("R11 irq enabled", {7'd0, irq_req}, 8'h01);
        wr_dc(8'hFB);
        chk("R11 mask with junk bits", {7'd0, irq_req}, 8'h00);
        chk("R11 no soft reset", {7'd0, soft_rst}, 8'h00);

        // R9 hardware reset clears soft reset
        wr_dc(8'h04);
        rst_n = 1'b0;
        step();
        chk("R9 hw reset clears srst", {7'd0, soft_rst}, 8'h00);
        rst_n = 1'b1;
        step();
        pulse_evt();
        chk("R8 nIEn 1 after hw reset", {7'd0, irq_req}, 8'h00);
        rd(4'hE, d2);
        chk("R2 after hw reset", d2, 8'h41);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule